// File: doc/BRIEF.md
# Misaligned Access Splitting Unit

This unit sits between a load/store pipeline and a memory bus that only carries naturally aligned transfers. It accepts one request at a time: a byte, 16-bit word or 32-bit longword operand with a byte address, a direction flag and write data. It turns the request into one, two or three aligned bus transfers. Each transfer is issued on a valid/ready handshake and then waits for a response strobe. Responses are returned for writes as well as reads.

Operands are big-endian. The first transfer covers the lowest address and carries the most significant bytes of the operand. On reads the unit shifts each returned piece in below the pieces that came before it. On writes it cuts the matching slice out of the operand. When the final response arrives it raises a one-cycle completion pulse. It also reports how many bus operations beyond the first the request needed, so the pipeline can account for the extra cost.

Top module: `unaligned_splitter`

## Requirements
- R1: A byte request (size code 0), a word (size code 1) at an even address, or a longword (size code 2) at an address with bits [1:0] = 00 produces exactly one bus transfer of the request's size at the request address, and extra_ops reads 0 at completion.
- R2: A word request at an odd address produces two byte transfers, at A and then A+1, and extra_ops reads 1.
- R3: A longword request with address bits [1:0] = 01 or 11 produces three transfers in this order: a byte at A, a word at A+1, a byte at A+3. extra_ops reads 2.
- R4: A longword request with address bits [1:0] = 10 produces two word transfers, at A and then A+2, and extra_ops reads 1.
- R5: On a write, each transfer carries its slice of the operand right-justified in bus_wdata. The bits above the slice are zero. The first transfer carries the most significant bytes. Only the low 1, 2 or 4 bytes of req_wdata form the operand.
- R6: On a read, rdata at completion holds the right-justified pieces concatenated in transfer order, first piece most significant, zero-extended to 32 bits. Bits of bus_rdata above each piece's width are ignored.
- R7: While bus_valid is high and bus_ready is low, bus_valid stays high and bus_addr, bus_size, bus_write and bus_wdata hold their values. bus_valid drops in the cycle after acceptance.
- R8: done is high for exactly one cycle, the cycle after the bus_rvalid of the final transfer. It stays low after the responses to earlier transfers.
- R9: req_ready is low from the cycle after a request is accepted until done. A req_valid presented during that time is ignored and does not change the transfers in progress.
- R10: Every bus transfer is naturally aligned: bus_size 1 has bus_addr[0] = 0, and bus_size 2 has bus_addr[1:0] = 00.
- R11: After reset, req_ready is 1 and bus_valid, done, extra_ops and rdata are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | 0 byte, 1 word, 2 longword |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write operand, right-justified |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read operand |
| extra_ops | output | 2 | Bus operations beyond the first |
| bus_valid | output | 1 | Transfer request to the bus |
| bus_ready | input | 1 | Bus accepts the transfer |
| bus_addr | output | ADDR_W | Aligned transfer address |
| bus_size | output | 2 | Transfer size code |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | 32 | Transfer write data, right-justified |
| bus_rvalid | input | 1 | Transfer response strobe |
| bus_rdata | input | 32 | Read response, right-justified |

## Verification
The bench sweeps all three sizes over all four address offsets, for both directions, at two base addresses. It compares the order, address, size and write slice of every transfer against a greedy aligned-chunk model. A wrong offset table would put the middle word of an odd longword at A+2 or split a 10 longword into bytes, and the placement checks would report it. A design that swaps endianness or skips masking the upper bus_rdata bits would assemble a different read operand, since the bench fills those bits with random garbage. Stalled bus_ready and delayed responses expose a request that changes before acceptance or a done raised on a middle response. Requests presented while the unit is busy expose a unit that lets a new request overwrite the one in progress.

// File: rtl/usplit_pkg.sv
package usplit_pkg;

  localparam int OP_W     = 32;
  localparam int OP_BYTES = OP_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } size_e;

  // Bytes covered by a size code (code 3 treated as a longword)
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Mask selecting a right-justified piece of the given size
  function automatic logic [OP_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // Number of aligned transfers needed for a request
  function automatic logic [1:0] piece_count(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      2'd0: return 2'd1;
      2'd1: return off[0] ? 2'd2 : 2'd1;
      default: begin
        case (off)
          2'd0:    return 2'd1;
          2'd2:    return 2'd2;
          default: return 2'd3;
        endcase
      end
    endcase
  endfunction

  // Size code of transfer number idx
  function automatic logic [1:0] piece_size(input logic [1:0] sz, input logic [1:0] off,
                                            input logic [1:0] idx);
    case (sz)
      2'd0: return 2'd0;
      2'd1: return off[0] ? 2'd0 : 2'd1;
      default: begin
        case (off)
          2'd0:    return 2'd2;
          2'd2:    return 2'd1;
          default: return (idx == 2'd1) ? 2'd1 : 2'd0;
        endcase
      end
    endcase
  endfunction

  // Byte offset of transfer number idx from the request address
  function automatic logic [1:0] piece_offset(input logic [1:0] sz, input logic [1:0] off,
                                              input logic [1:0] idx);
    case (sz)
      2'd0: return 2'd0;
      2'd1: return off[0] ? idx : 2'd0;
      default: begin
        case (off)
          2'd0:    return 2'd0;
          2'd2:    return (idx == 2'd0) ? 2'd0 : 2'd2;
          default: begin
            case (idx)
              2'd0:    return 2'd0;
              2'd1:    return 2'd1;
              default: return 2'd3;
            endcase
          end
        endcase
      end
    endcase
  endfunction

endpackage

// File: rtl/usplit_plan.sv
module usplit_plan
  import usplit_pkg::*;
(
  input  logic [1:0] op_size,
  input  logic [1:0] op_off,
  input  logic [1:0] idx,
  output logic [1:0] count,
  output logic [1:0] psize,
  output logic [1:0] poff
);

  always_comb begin
    count = piece_count(op_size, op_off);
    psize = piece_size(op_size, op_off, idx);
    poff  = piece_offset(op_size, op_off, idx);
  end

endmodule

// File: rtl/usplit_datapath.sv
module usplit_datapath
  import usplit_pkg::*;
(
  input  logic [OP_W-1:0] op_data,
  input  logic [1:0]      op_size,
  input  logic [1:0]      psize,
  input  logic [1:0]      poff,
  input  logic [OP_W-1:0] acc,
  input  logic [OP_W-1:0] piece_in,
  output logic [OP_W-1:0] wslice,
  output logic [OP_W-1:0] acc_next
);

  logic [2:0] nb, pb, rem;
  logic [5:0] wshift, ashift;
  logic [OP_W-1:0] pmask;

  always_comb begin
    nb     = size_bytes(op_size);
    pb     = size_bytes(psize);
    pmask  = size_mask(psize);
    // bytes of the operand that lie below this piece (big-endian)
    rem    = nb - {1'b0, poff} - pb;
    wshift = {rem, 3'b000};
    ashift = {pb, 3'b000};
    wslice = (op_data >> wshift) & pmask;
    acc_next = (ashift >= 6'd32) ? (piece_in & pmask)
                                 : ((acc << ashift) | (piece_in & pmask));
  end

endmodule

// File: rtl/unaligned_splitter.sv
module unaligned_splitter
  import usplit_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [OP_W-1:0]   req_wdata,
  output logic              done,
  output logic [OP_W-1:0]   rdata,
  output logic [1:0]        extra_ops,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic              bus_write,
  output logic [OP_W-1:0]   bus_wdata,
  input  logic              bus_rvalid,
  input  logic [OP_W-1:0]   bus_rdata
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} state_e;

  state_e            st;
  logic [ADDR_W-1:0] op_addr;
  logic [1:0]        op_size;
  logic              op_write;
  logic [OP_W-1:0]   op_data;
  logic [1:0]        idx;
  logic [OP_W-1:0]   acc;
  logic              done_q;
  logic [1:0]        extra_q;

  logic [1:0]        cnt, psize, poff;
  logic [OP_W-1:0]   wslice, acc_next;

  // named events for the checker
  logic ev_accept, ev_fire, ev_resp, ev_last;

  usplit_plan u_plan (
    .op_size (op_size),
    .op_off  (op_addr[1:0]),
    .idx     (idx),
    .count   (cnt),
    .psize   (psize),
    .poff    (poff)
  );

  usplit_datapath u_dp (
    .op_data  (op_data),
    .op_size  (op_size),
    .psize    (psize),
    .poff     (poff),
    .acc      (acc),
    .piece_in (bus_rdata),
    .wslice   (wslice),
    .acc_next (acc_next)
  );

  always_comb begin
    req_ready = (st == ST_IDLE);
    bus_valid = (st == ST_ISSUE);
    bus_addr  = op_addr + ADDR_W'(poff);
    bus_size  = psize;
    bus_write = op_write;
    bus_wdata = op_write ? wslice : '0;
    ev_accept = req_valid && req_ready;
    ev_fire   = bus_valid && bus_ready;
    ev_resp   = (st == ST_WAIT) && bus_rvalid;
    ev_last   = ev_resp && (idx == (cnt - 2'd1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      op_addr  <= '0;
      op_size  <= '0;
      op_write <= 1'b0;
      op_data  <= '0;
      idx      <= '0;
      acc      <= '0;
      done_q   <= 1'b0;
      extra_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (ev_accept) begin
            op_addr  <= req_addr;
            op_size  <= req_size;
            op_write <= req_write;
            op_data  <= req_wdata;
            idx      <= '0;
            acc      <= '0;
            extra_q  <= piece_count(req_size, req_addr[1:0]) - 2'd1;
            st       <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (ev_fire) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (ev_resp) begin
            if (!op_write) acc <= acc_next;
            if (ev_last) begin
              st     <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              idx <= idx + 2'd1;
              st  <= ST_ISSUE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign rdata     = acc;
  assign extra_ops = extra_q;

endmodule

// File: rtl/usplit_checker.sv
module usplit_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic              bus_write,
  input logic [31:0]       bus_wdata,
  input logic              done,
  input logic [1:0]        extra_ops,
  input logic              ev_last
);

  // R7: request held until the bus takes it
  a_r7_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_size)
                                 && $stable(bus_write) && $stable(bus_wdata));

  // R7: valid drops after acceptance
  a_r7_drop_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready |=> !bus_valid);

  // R10: natural alignment of every transfer
  a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_size == 2'd0) || (bus_size == 2'd1 && !bus_addr[0])
                  || (bus_size == 2'd2 && bus_addr[1:0] == 2'b00));

  // R9: no new request while a transfer is outstanding
  a_r9_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready);

  // R8: completion is a single-cycle pulse following the final response
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> done && req_ready);

  // R3: at most two extra operations
  a_r3_extra_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> extra_ops != 2'd3);

endmodule

bind unaligned_splitter usplit_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .bus_write (bus_write),
  .bus_wdata (bus_wdata),
  .done      (done),
  .extra_ops (extra_ops),
  .ev_last   (ev_last)
);

// File: tb/unaligned_splitter_test.sv
module unaligned_splitter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        done;
  logic [31:0] rdata;
  logic [1:0]  extra_ops;
  logic        bus_valid;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic        bus_write;
  logic [31:0] bus_wdata;
  logic        bus_rvalid = 1'b0;
  logic [31:0] bus_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  unaligned_splitter #(.ADDR_W(32)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .extra_ops(extra_ops),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic [31:0] len_mask(input int len);
    return (len == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * len)) - 32'h1);
  endfunction

  // One request, with an independent model of the expected transfers
  task automatic run_access(input logic [31:0] addr, input logic [1:0] sz,
                            input bit wr, input logic [31:0] data, input int seed);
    int nb, np, a, r;
    int p_off[3];
    int p_len[3];
    string tag;
    logic [31:0] exp_rd;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    // greedy largest aligned chunk that still fits
    np = 0; a = int'(addr[1:0]); r = nb;
    while (r > 0) begin
      int len;
      if (a % 4 == 0 && r >= 4) len = 4;
      else if (a % 2 == 0 && r >= 2) len = 2;
      else len = 1;
      p_off[np] = a - int'(addr[1:0]);
      p_len[np] = len;
      np++; a += len; r -= len;
    end
    if (np == 1) tag = "R1";
    else if (sz == 2'd1) tag = "R2";
    else if (np == 3) tag = "R3";
    else tag = "R4";

    check(req_ready == 1'b1, "R9 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = addr; req_size = sz; req_write = wr; req_wdata = data;
    @(negedge clk);
    // while busy, optionally keep presenting a conflicting request (R9)
    req_valid = (seed % 2) == 1;
    req_addr = ~addr; req_size = 2'd2 - sz; req_write = ~wr; req_wdata = ~data;
    check(req_ready == 1'b0, "R9 busy after accept", 32'(req_ready), 32'd0);
    exp_rd = '0;
    for (int p = 0; p < np; p++) begin
      logic [31:0] exp_w, pv;
      logic [1:0]  exp_sz;
      exp_sz = (p_len[p] == 1) ? 2'd0 : (p_len[p] == 2) ? 2'd1 : 2'd2;
      exp_w = '0;
      for (int j = 0; j < p_len[p]; j++) begin
        int bi;
        bi = p_off[p] + j;
        exp_w = (exp_w << 8) | 32'(data[8 * (nb - 1 - bi) +: 8]);
      end
      check(bus_valid == 1'b1, {tag, " transfer issued"}, 32'(bus_valid), 32'd1);
      check(bus_addr == addr + 32'(p_off[p]), {tag, " transfer address"}, bus_addr,
            addr + 32'(p_off[p]));
      check(bus_size == exp_sz, {tag, " transfer size"}, 32'(bus_size), 32'(exp_sz));
      check((bus_addr & 32'(p_len[p] - 1)) == 32'd0, "R10 natural alignment",
            bus_addr, bus_addr & ~32'(p_len[p] - 1));
      check(bus_write == wr, "R5 transfer direction", 32'(bus_write), 32'(wr));
      if (wr) check(bus_wdata == exp_w, "R5 write slice", bus_wdata, exp_w);
      for (int s = 0; s < (seed + p) % 3; s++) begin
        logic [31:0] held;
        held = bus_addr;
        bus_ready = 1'b0;
        @(negedge clk);
        check(bus_valid == 1'b1 && bus_addr == held, "R7 held during stall", bus_addr, held);
        if (wr) check(bus_wdata == exp_w, "R7 data held", bus_wdata, exp_w);
      end
      bus_ready = 1'b1;
      @(negedge clk);
      bus_ready = 1'b0;
      check(bus_valid == 1'b0, "R7 valid drops after accept", 32'(bus_valid), 32'd0);
      check(req_ready == 1'b0, "R9 busy while waiting", 32'(req_ready), 32'd0);
      for (int d = 0; d < seed % 2; d++) @(negedge clk);
      pv = $urandom();
      bus_rdata = pv; bus_rvalid = 1'b1;
      exp_rd = (p_len[p] == 4) ? (pv & len_mask(4))
                               : ((exp_rd << (8 * p_len[p])) | (pv & len_mask(p_len[p])));
      if (p == np - 1) req_valid = 1'b0;
      @(negedge clk);
      bus_rvalid = 1'b0; bus_rdata = '0;
      if (p != np - 1) begin
        check(done == 1'b0, "R8 no done on middle response", 32'(done), 32'd0);
      end else begin
        check(done == 1'b1, "R8 done after last response", 32'(done), 32'd1);
        check(extra_ops == 2'(np - 1), {tag, " extra operation count"}, 32'(extra_ops),
              32'(np - 1));
        if (!wr) check(rdata == exp_rd, "R6 assembled read", rdata, exp_rd);
      end
    end
    @(negedge clk);
    check(done == 1'b0, "R8 done is one cycle", 32'(done), 32'd0);
    check(bus_valid == 1'b0, "R9 busy request ignored", 32'(bus_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] bases [2];
    bases[0] = 32'h0000_1000;
    bases[1] = 32'hA5C3_7F20;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R11 reset ready", 32'(req_ready), 32'd1);
    check(bus_valid == 1'b0, "R11 reset bus idle", 32'(bus_valid), 32'd0);
    check(done == 1'b0, "R11 reset done", 32'(done), 32'd0);
    check(extra_ops == 2'd0, "R11 reset extra", 32'(extra_ops), 32'd0);
    check(rdata == 32'd0, "R11 reset rdata", rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int b = 0; b < 2; b++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off++)
          for (int wr = 0; wr < 2; wr++)
            run_access(bases[b] + 32'(off), 2'(sz), wr[0], $urandom(),
                       b * 24 + sz * 8 + off * 2 + wr);
    summary();
    $finish;
  end

endmodule